// File: doc/BRIEF.md
# PMP Region Address Decoder

This combinational block turns the settings of one memory-protection entry into an inclusive byte range. It takes three inputs: the entry's address register, the address register of the entry below it, and the entry's two-bit matching mode. From these it produces a start address and an end address. A matcher placed downstream compares access addresses against these two bounds. The design uses one instance per entry.

All arithmetic is done at the physical address width `ADDR_W`. The address register is treated as a word address: it is shifted left by two before use, and the bits shifted out are dropped. The parameter `IS_FIRST` marks the lowest entry. In top-of-range mode that entry has no neighbour below it, so it uses zero as its lower limit.

Top module: `pmp_region_decoder`

## Requirements
- R1: With mode 0 (off), start_o is 0 and end_o is all ones, whatever the address inputs are.
- R2: With mode 1 (top of range), start_o is prev_addr_i shifted left by 2 and end_o is cur_addr_i shifted left by 2 minus 1, both modulo 2^ADDR_W, when start does not exceed end.
- R3: In mode 1, when the computed start is greater than the computed end, both start_o and end_o are 0.
- R4: With IS_FIRST set, mode 1 uses 0 as the lower limit and prev_addr_i has no effect on either output.
- R5: With mode 2 (naturally aligned 4 bytes), start_o is cur_addr_i shifted left by 2 and end_o is start_o plus 3.
- R6: With mode 3 (naturally aligned power of two), let k be the number of trailing ones in cur_addr_i. The region is 2^(k+3) bytes, aligned to its size. start_o is the shifted address with its low k+3 bits cleared, and end_o is the same address with those bits set.
- R7: In mode 3, when k+3 is at least ADDR_W, the region is the whole space: start_o is 0 and end_o is all ones.
- R8: Bits of an address register shifted above bit ADDR_W-1 are discarded and have no effect on either output.
- R9: In every mode, start_o is less than or equal to end_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| region_mode_i | input | 2 | Matching mode: 0 off, 1 top of range, 2 aligned 4 bytes, 3 aligned power of two |
| cur_addr_i | input | ADDR_W | This entry's address register (word address) |
| prev_addr_i | input | ADDR_W | Address register of the entry below; used in mode 1 only |
| start_o | output | ADDR_W | Inclusive first byte address of the region |
| end_o | output | ADDR_W | Inclusive last byte address of the region |

## Verification
The bench builds two instances. The first uses the default ADDR_W of 34 with IS_FIRST clear, which exercises wide arithmetic and the use of the neighbour's register. The second uses ADDR_W of 8 with IS_FIRST set. With only 256 possible register values, random stimulus there often reaches the all-ones aligned region, the wrap of end below zero, the loss of bits on truncation, and the lowest-entry rule in which prev_addr_i is ignored.

// File: rtl/pmp_dec_pkg.sv
package pmp_dec_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } region_mode_e;

endpackage

// File: rtl/pmp_tor_range.sv
module pmp_tor_range #(
  parameter int ADDR_W = 34
) (
  input  logic [ADDR_W-1:0] lo_reg_i,
  input  logic [ADDR_W-1:0] hi_reg_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o
);
  logic [ADDR_W-1:0] lo_byte, hi_byte, hi_last;

  assign lo_byte = lo_reg_i << 2;
  assign hi_byte = hi_reg_i << 2;
  assign hi_last = hi_byte - ADDR_W'(1);

  always_comb begin
    if (lo_byte > hi_last) begin
      start_o = '0;
      end_o   = '0;
    end else begin
      start_o = lo_byte;
      end_o   = hi_last;
    end
  end
endmodule

// File: rtl/pmp_na4_range.sv
module pmp_na4_range #(
  parameter int ADDR_W = 34
) (
  input  logic [ADDR_W-1:0] reg_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o
);
  logic [ADDR_W-1:0] base;

  assign base    = reg_i << 2;
  assign start_o = base;
  assign end_o   = base + ADDR_W'(3);
endmodule

// File: rtl/pmp_napot_range.sv
module pmp_napot_range #(
  parameter int ADDR_W = 34
) (
  input  logic [ADDR_W-1:0] reg_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o
);
  logic [ADDR_W-1:0] filled, bumped;

  // low ones of filled mark the size; incrementing flips them into one carry bit
  assign filled  = (reg_i << 2) | ADDR_W'(3);
  assign bumped  = filled + ADDR_W'(1);
  assign start_o = filled & bumped;
  assign end_o   = filled | bumped;
endmodule

// File: rtl/pmp_region_decoder.sv
module pmp_region_decoder
  import pmp_dec_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter bit IS_FIRST = 1'b0
) (
  input  logic [1:0]        region_mode_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ADDR_W-1:0] prev_addr_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o
);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  region_mode_e      mode;
  logic [ADDR_W-1:0] lo_reg;
  logic [ADDR_W-1:0] tor_s, tor_e, na4_s, na4_e, pot_s, pot_e;

  assign mode = region_mode_e'(region_mode_i);

  generate
    if (IS_FIRST) begin : g_first
      assign lo_reg = prev_addr_i & {ADDR_W{1'b0}};
    end else begin : g_chain
      assign lo_reg = prev_addr_i;
    end
  endgenerate

  pmp_tor_range #(.ADDR_W(ADDR_W)) u_tor (
    .lo_reg_i(lo_reg), .hi_reg_i(cur_addr_i), .start_o(tor_s), .end_o(tor_e)
  );

  pmp_na4_range #(.ADDR_W(ADDR_W)) u_na4 (
    .reg_i(cur_addr_i), .start_o(na4_s), .end_o(na4_e)
  );

  pmp_napot_range #(.ADDR_W(ADDR_W)) u_pot (
    .reg_i(cur_addr_i), .start_o(pot_s), .end_o(pot_e)
  );

  always_comb begin
    unique case (mode)
      MODE_TOR:   begin start_o = tor_s; end_o = tor_e; end
      MODE_NA4:   begin start_o = na4_s; end_o = na4_e; end
      MODE_NAPOT: begin start_o = pot_s; end_o = pot_e; end
      default:    begin start_o = '0;    end_o = ALL_ONES; end
    endcase
  end
endmodule

// File: rtl/pmp_region_decoder_chk.sv
module pmp_region_decoder_chk #(
  parameter int ADDR_W = 34
) (
  input logic [1:0]        region_mode_i,
  input logic [ADDR_W-1:0] cur_addr_i,
  input logic [ADDR_W-1:0] start_o,
  input logic [ADDR_W-1:0] end_o
);
  logic [ADDR_W-1:0] span;
  assign span = start_o ^ end_o;

  always_comb begin
    if (!$isunknown({region_mode_i, cur_addr_i, start_o, end_o})) begin
      assert_ordered_R9: assert (start_o <= end_o);
      if (region_mode_i == 2'd0) begin
        assert_off_full_R1: assert (start_o == '0 && ~end_o == '0);
      end
      if (region_mode_i == 2'd2) begin
        assert_na4_span_R5: assert (end_o - start_o == ADDR_W'(3) && start_o[1:0] == 2'b00);
      end
      if (region_mode_i == 2'd3) begin
        // span must be a run of low ones, no shorter than 8 bytes, start aligned to it
        assert_pot_shape_R6: assert ((span & (span + ADDR_W'(1))) == '0 &&
                                     span[2:0] == 3'b111 && (start_o & span) == '0);
      end
      if (region_mode_i == 2'd1 && start_o != end_o) begin
        assert_tor_top_R2: assert (end_o + ADDR_W'(1) == ADDR_W'(cur_addr_i << 2));
      end
    end
  end
endmodule

bind pmp_region_decoder pmp_region_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .region_mode_i(region_mode_i), .cur_addr_i(cur_addr_i),
  .start_o(start_o), .end_o(end_o)
);

// File: tb/pmp_region_decoder_test.sv
`timescale 1ns/1ps
module pmp_region_decoder_test;
  localparam int W_A = 34;
  localparam int W_B = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]     mode_a, mode_b;
  logic [W_A-1:0] cur_a, prev_a, s_a, e_a;
  logic [W_B-1:0] cur_b, prev_b, s_b, e_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pmp_region_decoder #(.ADDR_W(W_A), .IS_FIRST(1'b0)) uut (
    .region_mode_i(mode_a), .cur_addr_i(cur_a), .prev_addr_i(prev_a),
    .start_o(s_a), .end_o(e_a)
  );

  pmp_region_decoder #(.ADDR_W(W_B), .IS_FIRST(1'b1)) uut_e0 (
    .region_mode_i(mode_b), .cur_addr_i(cur_b), .prev_addr_i(prev_b),
    .start_o(s_b), .end_o(e_b)
  );

  function automatic logic [127:0] model(input logic [1:0] m, input logic [63:0] a,
                                         input logic [63:0] p, input int w);
    logic [63:0] mask, s, e, lowm;
    int k;
    mask = (64'd1 << w) - 64'd1;
    a = a & mask;
    p = p & mask;
    case (m)
      2'd0: begin s = 0; e = mask; end
      2'd1: begin
        s = (p << 2) & mask;
        e = ((a << 2) - 64'd1) & mask;
        if (s > e) begin s = 0; e = 0; end
      end
      2'd2: begin s = (a << 2) & mask; e = s + 64'd3; end
      default: begin
        k = 0;
        while (k < w && a[k]) k++;
        if (k + 3 >= w) begin s = 0; e = mask; end
        else begin
          lowm = (64'd1 << (k + 3)) - 64'd1;
          s = (a << 2) & mask & ~lowm;
          e = s | lowm;
        end
      end
    endcase
    return {s, e};
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] as, input logic [63:0] ae,
                     input logic [127:0] ex);
    n_run++;
    if (as !== ex[127:64] || ae !== ex[63:0]) begin
      n_fail++;
      $display("FAIL %s: got start=%h end=%h expected start=%h end=%h",
               tag, as, ae, ex[127:64], ex[63:0]);
    end
  endtask

  task automatic drive_a(input logic [1:0] m, input logic [63:0] a, input logic [63:0] p);
    @(posedge clk);
    mode_a = m; cur_a = a[W_A-1:0]; prev_a = p[W_A-1:0];
    @(negedge clk);
  endtask

  task automatic drive_b(input logic [1:0] m, input logic [63:0] a, input logic [63:0] p);
    @(posedge clk);
    mode_b = m; cur_b = a[W_B-1:0]; prev_b = p[W_B-1:0];
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 11;
    void'($urandom(seed));
    mode_a = 2'd0; cur_a = '0; prev_a = '0;
    mode_b = 2'd0; cur_b = '0; prev_b = '0;
    @(negedge clk);
    // R1: initial off state
    chk("R1", 64'(s_a), 64'(e_a), {64'd0, 64'h3_FFFF_FFFF});
    chk("R1", 64'(s_b), 64'(e_b), {64'd0, 64'hFF});

    drive_a(2'd0, 64'h2_1234_5678, 64'h1_0000_0001);
    chk("R1", 64'(s_a), 64'(e_a), {64'd0, 64'h3_FFFF_FFFF});

    drive_a(2'd1, 64'h20, 64'h10);
    chk("R2", 64'(s_a), 64'(e_a), {64'h40, 64'h7F});
    drive_a(2'd1, 64'h0, 64'h0);
    chk("R2", 64'(s_a), 64'(e_a), {64'd0, 64'h3_FFFF_FFFF});

    drive_a(2'd1, 64'h20, 64'h30);
    chk("R3", 64'(s_a), 64'(e_a), {64'd0, 64'd0});
    drive_a(2'd1, 64'h20, 64'h20);
    chk("R3", 64'(s_a), 64'(e_a), {64'd0, 64'd0});

    drive_b(2'd1, 64'h10, 64'hFF);
    chk("R4", 64'(s_b), 64'(e_b), {64'd0, 64'h3F});
    drive_b(2'd1, 64'h10, 64'h05);
    chk("R4", 64'(s_b), 64'(e_b), {64'd0, 64'h3F});

    drive_a(2'd2, 64'h5, 64'h0);
    chk("R5", 64'(s_a), 64'(e_a), {64'h14, 64'h17});

    drive_a(2'd3, 64'h1000, 64'h0);
    chk("R6", 64'(s_a), 64'(e_a), {64'h4000, 64'h4007});
    drive_a(2'd3, 64'h1007, 64'h0);
    chk("R6", 64'(s_a), 64'(e_a), {64'h4000, 64'h403F});

    drive_b(2'd3, 64'hFF, 64'h0);
    chk("R7", 64'(s_b), 64'(e_b), {64'd0, 64'hFF});
    drive_b(2'd3, 64'h1F, 64'h0);
    chk("R7", 64'(s_b), 64'(e_b), {64'd0, 64'hFF});

    drive_b(2'd2, 64'hC1, 64'h0);
    chk("R8", 64'(s_b), 64'(e_b), {64'h04, 64'h07});
    drive_a(2'd2, 64'h3_0000_0002, 64'h0);
    chk("R8", 64'(s_a), 64'(e_a), {64'h8, 64'hB});

    drive_a(2'd2, 64'h3_FFFF_FFFF, 64'h0);
    chk("R9", 64'(s_a), 64'(e_a), {64'h3_FFFF_FFFC, 64'h3_FFFF_FFFF});

    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  m;
      logic [63:0] a, p;
      m = 2'($urandom);
      a = {$urandom, $urandom};
      p = {$urandom, $urandom};
      if ($urandom % 8 == 0) a = a | 64'hFF;
      drive_a(m, a, p);
      chk(tag_of(m), 64'(s_a), 64'(e_a), model(m, a, p, W_A));
      drive_b(m, a, p);
      chk(m == 2'd1 ? "R4" : tag_of(m), 64'(s_b), 64'(e_b), model(m, a, 64'd0, W_B));
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule